// File: doc/BRIEF.md
# ATM Cell Delineation HEC Hunter

This block recovers 53-byte cell boundaries from a raw nibble stream that carries no framing marks. Every cell opens with a five-byte header. The last header byte is a check byte computed over the first four bytes. The block tries one candidate boundary at a time. It runs an 8-bit CRC over the eight nibbles that would form the first four header bytes, then compares the result with the two nibbles that follow. A failed candidate restarts the CRC one bit later in the stream. Because of this, a boundary that falls between the bits of a nibble is still found.

A matching candidate starts a confirmation phase. Lock is declared only once the check byte is also correct in the following cells, each 53 bytes apart. Once locked, the block passes out every cell realigned to nibble boundaries. It marks the first header nibble with a strobe and flags which nibbles belong to the header. Isolated bad check bytes do not break lock; only a long run of them does. The input strobe may drop at any cycle, and everything simply stalls while it is low.

Top module: `atm_hec_hunter`

## Requirements
- R1: After reset the block is hunting, and locked_o, sop_o and nib_vld_o are all low.
- R2: The check byte is the CRC of header bytes one to four, taken MSB first with polynomial x^8+x^2+x+1 and a zero start value, XORed with 0x55. A stream whose check bytes omit the 0x55 never produces lock.
- R3: data_i[3] is the earliest bit of each nibble. Each rejected candidate moves the boundary one bit later, so lock is reached whatever the bit offset of the cell boundary inside the nibbles.
- R4: Lock (locked_o high) follows a first match plus six further consecutive correct check bytes at 106-nibble spacing. Any bad check byte before that restarts the hunt, so a stream that repeats six good cells and one bad cell never locks, while seven good and one bad does lock.
- R5: While locked, up to six consecutive bad check bytes keep lock and the affected cells are still delivered. The seventh consecutive bad one drops lock and restarts the hunt.
- R6: sop_o pulses together with the first header nibble of every cell, only while locked, with exactly 106 output nibbles from one pulse to the next.
- R7: While locked, nib_o/nib_vld_o deliver every realigned nibble of each cell in stream order, 106 per cell, and hdr_o is high on exactly the first ten of them.
- R8: Cycles with valid_i low are ignored: they neither advance the hunt nor disturb the output, and lock and cell delivery work with such gaps present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | data_i carries a nibble this cycle |
| data_i | input | 4 | Raw stream nibble, bit 3 earliest |
| locked_o | output | 1 | Cell alignment confirmed |
| sop_o | output | 1 | First header nibble of a cell on nib_o |
| nib_vld_o | output | 1 | nib_o carries an aligned nibble |
| nib_o | output | 4 | Realigned cell nibble |
| hdr_o | output | 1 | Current nib_o belongs to the five-byte header |

## Verification
The bench places cell boundaries at several offsets that are not a whole number of nibbles, with and without input gaps. A realigner that slipped by whole nibbles only, or that mishandled the wrap from the last bit position, would never lock on these streams. It also sends a stream whose check bytes lack the coset; a hunter that skipped the XOR would lock on it. Periodic patterns of six good and one bad, and of seven good and one bad, probe the confirmation count in both directions, where an off-by-one count either locks too early or never locks. Bursts of six and then seven bad check bytes during lock probe the loss threshold. Every cell delivered is compared whole against the sent data, so a wrong phase or a dropped nibble shows up as a content mismatch.

// File: rtl/atm_hunt_pkg.sv
package atm_hunt_pkg;
  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_PRESYNC = 2'd1,
    ST_SYNC    = 2'd2
  } sync_st_e;
endpackage

// File: rtl/nib_realign.sv
// Bit-granular realigner: selects a nibble from a two-nibble window at a
// slip offset; a slip past the last offset drops one nibble instead.
module nib_realign #(
  parameter int NIB_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [NIB_W-1:0] dat_i,
  input  logic             slip_i,
  output logic [NIB_W-1:0] nib_o,
  output logic             vld_o
);
  localparam int SH_W = (NIB_W > 1) ? $clog2(NIB_W) : 1;

  logic [NIB_W-1:0]   prev_q;
  logic [SH_W-1:0]    sh_q;
  logic               skip_q;
  logic [2*NIB_W-1:0] win, win_sh;

  assign win    = {prev_q, dat_i};
  assign win_sh = win << sh_q;
  assign nib_o  = win_sh[2*NIB_W-1 -: NIB_W];
  assign vld_o  = vld_i && !skip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      sh_q   <= '0;
      skip_q <= 1'b0;
    end else if (vld_i) begin
      prev_q <= dat_i;
      if (skip_q) begin
        skip_q <= 1'b0;
      end else if (slip_i) begin
        if (sh_q == SH_W'(NIB_W-1)) begin
          sh_q   <= '0;
          skip_q <= 1'b1;
        end else begin
          sh_q <= sh_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hec_crc8.sv
// Nibble-serial CRC, MSB first; seed_i restarts from zero with this nibble.
module hec_crc8 #(
  parameter int              NIB_W = 4,
  parameter int              CRC_W = 8,
  parameter logic [CRC_W-1:0] POLY = 8'h07
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             seed_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q, crc_d;

  always_comb begin
    logic fb;
    crc_d = seed_i ? '0 : crc_q;
    for (int i = NIB_W-1; i >= 0; i--) begin
      fb    = crc_d[CRC_W-1] ^ nib_i[i];
      crc_d = {crc_d[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= '0;
    else if (en_i) crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/hec_sync_fsm.sv
module hec_sync_fsm import atm_hunt_pkg::*; #(
  parameter int GOOD_N = 6,
  parameter int BAD_N  = 7
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     eval_i,
  input  logic     ok_i,
  output sync_st_e state_o,
  output logic     slip_o
);
  localparam int CNT_MAX = (GOOD_N > BAD_N) ? GOOD_N : BAD_N;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  sync_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    slip_o = 1'b0;
    if (eval_i) begin
      unique case (st_q)
        ST_HUNT: begin
          if (ok_i) begin
            st_d  = ST_PRESYNC;
            cnt_d = '0;
          end else begin
            slip_o = 1'b1;
          end
        end
        ST_PRESYNC: begin
          if (!ok_i) begin
            st_d   = ST_HUNT;
            slip_o = 1'b1;
          end else if (cnt_q == CNT_W'(GOOD_N-1)) begin
            st_d  = ST_SYNC;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_SYNC: begin
          if (ok_i) begin
            cnt_d = '0;
          end else if (cnt_q == CNT_W'(BAD_N-1)) begin
            st_d   = ST_HUNT;
            cnt_d  = '0;
            slip_o = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          st_d  = ST_HUNT;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_HUNT;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/atm_hec_hunter.sv
module atm_hec_hunter import atm_hunt_pkg::*; #(
  parameter int         NIB_W      = 4,
  parameter int         CELL_BYTES = 53,
  parameter int         HDR_BYTES  = 5,
  parameter int         GOOD_N     = 6,
  parameter int         BAD_N      = 7,
  parameter logic [7:0] COSET      = 8'h55,
  parameter logic [7:0] POLY       = 8'h07
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [NIB_W-1:0] data_i,
  output logic             locked_o,
  output logic             sop_o,
  output logic             nib_vld_o,
  output logic [NIB_W-1:0] nib_o,
  output logic             hdr_o
);
  localparam int NPB       = 8 / NIB_W;
  localparam int CELL_NIBS = CELL_BYTES * NPB;
  localparam int HDR_NIBS  = HDR_BYTES * NPB;
  localparam int CRC_NIBS  = (HDR_BYTES - 1) * NPB;
  localparam int IDX_W     = $clog2(CELL_NIBS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CELL_NIBS - 1);
  localparam logic [IDX_W-1:0] IDX_HEC0 = IDX_W'(CRC_NIBS);
  localparam logic [IDX_W-1:0] IDX_HDR  = IDX_W'(HDR_NIBS);
  localparam logic [IDX_W-1:0] IDX_EVAL = IDX_W'(HDR_NIBS - 1);

  logic [NIB_W-1:0] al_nib;
  logic             al_vld;
  logic             slip;
  sync_st_e         sync_state;
  logic [IDX_W-1:0] idx_q, hec_k;
  logic [7:0]       crc_q, crc_x, crc_sh;
  logic             nib_match, in_hec, eval, hec_ok, run_q, in_sync;

  nib_realign #(.NIB_W(NIB_W)) u_align (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (valid_i),
    .dat_i  (data_i),
    .slip_i (slip),
    .nib_o  (al_nib),
    .vld_o  (al_vld)
  );

  hec_crc8 #(.NIB_W(NIB_W), .CRC_W(8), .POLY(POLY)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (al_vld && (idx_q < IDX_HEC0)),
    .seed_i (idx_q == '0),
    .nib_i  (al_nib),
    .crc_o  (crc_q)
  );

  // check-byte nibble expected at this header position
  assign crc_x     = crc_q ^ COSET;
  assign hec_k     = idx_q - IDX_HEC0;
  assign crc_sh    = crc_x << (32'(hec_k) * NIB_W);
  assign nib_match = (crc_sh[7 -: NIB_W] == al_nib);
  assign in_hec    = (idx_q >= IDX_HEC0) && (idx_q < IDX_HDR);
  assign hec_ok    = ((idx_q == IDX_HEC0) ? 1'b1 : run_q) && nib_match;
  assign eval      = al_vld && (idx_q == IDX_EVAL);

  hec_sync_fsm #(.GOOD_N(GOOD_N), .BAD_N(BAD_N)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .eval_i  (eval),
    .ok_i    (hec_ok),
    .state_o (sync_state),
    .slip_o  (slip)
  );

  assign in_sync  = (sync_state == ST_SYNC);
  assign locked_o = in_sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      run_q <= 1'b0;
    end else if (al_vld) begin
      if (in_hec) run_q <= hec_ok;
      if (slip || idx_q == IDX_LAST) idx_q <= '0;
      else                           idx_q <= idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sop_o     <= 1'b0;
      nib_vld_o <= 1'b0;
      hdr_o     <= 1'b0;
      nib_o     <= '0;
    end else begin
      sop_o     <= al_vld && in_sync && (idx_q == '0);
      nib_vld_o <= al_vld && in_sync;
      hdr_o     <= al_vld && (idx_q < IDX_HDR);
      if (al_vld) nib_o <= al_nib;
    end
  end
endmodule

// File: rtl/atm_hec_hunter_chk.sv
module atm_hec_hunter_chk import atm_hunt_pkg::*; #(
  parameter int CELL_NIBS = 106
) (
  input logic     clk_i,
  input logic     rst_ni,
  input logic     locked_o,
  input logic     sop_o,
  input logic     nib_vld_o,
  input sync_st_e st
);
  int unsigned n_q;
  logic        seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q    <= 0;
      seen_q <= 1'b0;
    end else begin
      if (nib_vld_o) n_q <= sop_o ? 1 : n_q + 1;
      if (sop_o)                       seen_q <= 1'b1;
      else if (!locked_o && !nib_vld_o) seen_q <= 1'b0;
    end
  end

  p_sop_locked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_o |-> locked_o);

  p_sop_vld_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_o |-> nib_vld_o);

  p_cell_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sop_o && seen_q) |-> (n_q == CELL_NIBS));

  p_vld_locked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_vld_o |-> (locked_o || $past(locked_o)));

  p_sync_via_presync_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_SYNC && $past(st) != ST_SYNC) |-> ($past(st) == ST_PRESYNC));
endmodule

bind atm_hec_hunter atm_hec_hunter_chk #(.CELL_NIBS(CELL_NIBS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .locked_o  (locked_o),
  .sop_o     (sop_o),
  .nib_vld_o (nib_vld_o),
  .st        (sync_state)
);

// File: tb/atm_hec_hunter_test.sv
module atm_hec_hunter_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] data_i = 4'h0;
  logic       locked_o, sop_o, nib_vld_o, hdr_o;
  logic [3:0] nib_o;

  atm_hec_hunter uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .locked_o(locked_o), .sop_o(sop_o), .nib_vld_o(nib_vld_o),
    .nib_o(nib_o), .hdr_o(hdr_o)
  );

  always #10 clk_i = ~clk_i;

  int           n_chk = 0, n_bad = 0;
  bit           bitq[$];
  logic [423:0] exp_q[$];
  int           id_ctr = 1;
  bit           gap_en = 0;
  int           nib_ctr = 0;
  bit           lock_seen = 0;
  int           cells_ok = 0;
  bit           act = 0;
  int           cnt = 0;
  logic [423:0] got;

  task automatic check(input bit cond, input string req, input string what,
                       input longint act_v, input longint exp_v);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
    end
  endtask

  function automatic logic [7:0] crc_ref(input logic [31:0] h);
    logic [7:0] c = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      logic fb;
      fb = c[7] ^ h[i];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  task automatic drive_nib(input logic [3:0] n);
    @(negedge clk_i);
    data_i  = n;
    valid_i = 1'b1;
    nib_ctr++;
    if (gap_en && (nib_ctr % 5 == 0)) begin
      @(negedge clk_i);
      valid_i = 1'b0;
    end
  endtask

  // mode 0: good, 1: corrupted check byte, 2: check byte without coset
  task automatic send_cell(input int mode);
    logic [423:0] v;
    logic [31:0]  h;
    logic [7:0]   hec;
    h   = {id_ctr[15:0], 8'hA5 ^ id_ctr[7:0], 8'h3C ^ id_ctr[15:8]};
    hec = crc_ref(h) ^ ((mode == 2) ? 8'h00 : 8'h55) ^ ((mode == 1) ? 8'h80 : 8'h00);
    v[423:384] = {h, hec};
    for (int j = 0; j < 48; j++) v[383-8*j -: 8] = 8'((id_ctr * 7 + j * 29) ^ 8'h6B);
    exp_q.push_back(v);
    id_ctr++;
    for (int b = 423; b >= 0; b--) bitq.push_back(v[b]);
    while (bitq.size() >= 4) begin
      drive_nib({bitq[0], bitq[1], bitq[2], bitq[3]});
      repeat (4) void'(bitq.pop_front());
    end
  endtask

  task automatic idle();
    @(negedge clk_i);
    valid_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic phase_start(input int off, input bit gaps);
    @(negedge clk_i);
    rst_ni  = 1'b0;
    valid_i = 1'b0;
    bitq.delete();
    exp_q.delete();
    repeat (3) @(negedge clk_i);
    rst_ni    = 1'b1;
    gap_en    = gaps;
    lock_seen = 0;
    cells_ok  = 0;
    for (int i = 0; i < off; i++) bitq.push_back(1'b1);
  endtask

  // monitor: scoreboard of delivered cells against sent ones
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      act = 0;
    end else begin
      if (locked_o) lock_seen = 1;
      if (sop_o) check(locked_o, "R6", "sop_o outside lock", locked_o, 1);
      if (nib_vld_o) begin
        if (sop_o) begin
          check(!act, "R6", "sop_o inside a cell at nibble", cnt, 0);
          act = 1;
          cnt = 0;
        end
        if (act) begin
          check(hdr_o == (cnt < 10), "R7", "hdr_o", hdr_o, (cnt < 10));
          got = {got[419:0], nib_o};
          cnt++;
          if (cnt == 106) begin
            act = 0;
            while (exp_q.size() > 0 && exp_q[0][423:408] != got[423:408])
              void'(exp_q.pop_front());
            if (exp_q.size() == 0) begin
              check(0, "R7", "unexpected cell id", got[423:408], 0);
            end else begin
              check(exp_q[0] == got, "R7", "cell content id", got[423:408], exp_q[0][423:408]);
              void'(exp_q.pop_front());
              cells_ok++;
            end
          end
        end
      end else if (!locked_o) begin
        act = 0;
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (195000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 195000, 0);
    summary();
    $finish;
  end

  initial begin
    int n;
    // R1: reset state
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(locked_o == 0, "R1", "locked_o after reset", locked_o, 0);
    check(sop_o == 0, "R1", "sop_o after reset", sop_o, 0);
    check(nib_vld_o == 0, "R1", "nib_vld_o after reset", nib_vld_o, 0);

    // R2: check bytes without coset must never lock
    phase_start(0, 0);
    repeat (80) send_cell(2);
    idle();
    check(!lock_seen, "R2", "lock without coset", lock_seen, 0);

    // R3: boundary 3 bits into a nibble
    phase_start(3, 0);
    n = 0;
    while (!locked_o && n < 100) begin send_cell(0); n++; end
    check(locked_o, "R3", "lock at bit offset 3", locked_o, 1);
    repeat (10) send_cell(0);
    idle();
    check(cells_ok >= 8, "R7", "cells delivered at offset 3", cells_ok, 8);

    // R8: boundary 6 bits in, valid_i gaps
    phase_start(6, 1);
    n = 0;
    while (!locked_o && n < 100) begin send_cell(0); n++; end
    check(locked_o, "R8", "lock with input gaps", locked_o, 1);
    repeat (10) send_cell(0);
    idle();
    check(cells_ok >= 8, "R8", "cells delivered with gaps", cells_ok, 8);

    // R5: loss threshold
    cells_ok = 0;
    repeat (6) send_cell(1);
    repeat (3) send_cell(0);
    idle();
    check(locked_o, "R5", "lock after 6 bad check bytes", locked_o, 1);
    check(cells_ok >= 8, "R5", "cells delivered across bad burst", cells_ok, 8);
    repeat (7) send_cell(1);
    send_cell(0);
    idle();
    check(!locked_o, "R5", "lock after 7 bad check bytes", locked_o, 0);

    // R4: six good then one bad never confirms
    phase_start(1, 0);
    for (int k = 0; k < 200; k++) send_cell((k % 7 == 6) ? 1 : 0);
    idle();
    check(!lock_seen, "R4", "lock with 6 good / 1 bad", lock_seen, 0);

    // R4: seven good then one bad confirms
    phase_start(2, 0);
    n = 0;
    while (!locked_o && n < 800) begin send_cell((n % 8 == 7) ? 1 : 0); n++; end
    check(locked_o, "R4", "lock with 7 good / 1 bad", locked_o, 1);
    cells_ok = 0;
    repeat (16) begin send_cell((n % 8 == 7) ? 1 : 0); n++; end
    idle();
    check(cells_ok >= 14, "R7", "cells delivered after periodic lock", cells_ok, 14);
    check(locked_o, "R5", "single bad cells keep lock", locked_o, 1);

    summary();
    $finish;
  end
endmodule